// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine with Redraw Queue

This block runs rectangle fill and rectangle copy operations against a linear, byte-addressed framebuffer. The pixel size in bytes (1 to 4) and the screen width and height come from configuration inputs. The engine drives a simple memory port with one write lane and one read lane. The read data is expected in the same cycle, so the engine moves one byte per clock.

A fill works in two steps. It first paints the colour across the top row of the rectangle. It then copies that top row into every row below it. A copy picks its traversal direction from the two base addresses. When the destination starts at a higher address than the source, it walks the rectangle from the last byte backward. Otherwise it walks forward. In both cases overlapping source and destination rectangles end with the correct contents.

Each finished operation records its destination rectangle in a power-of-two redraw queue. A flush request either streams the queued rectangles out in order, clipped to the screen, or throws them all away if an invalidate arrived since the last flush.

States: `ST_IDLE` (accepts an operation or a flush), `ST_FILL_FIRST` (paints the top row), `ST_FILL_REPL` (replicates the top row downward), `ST_COPY` (moves bytes), `ST_RECORD` (pushes the destination rectangle), `ST_DRAIN` (emits queued rectangles).

Transitions:
- `ST_IDLE` to `ST_RECORD` on an operation with zero width or zero height.
- `ST_IDLE` to `ST_FILL_FIRST` on a fill.
- `ST_IDLE` to `ST_COPY` on a copy.
- `ST_IDLE` to `ST_DRAIN` on a flush when nothing is pending and the queue is not empty.
- `ST_FILL_FIRST` to `ST_RECORD` on the last byte when the rectangle is one row high.
- `ST_FILL_FIRST` to `ST_FILL_REPL` on the last byte otherwise.
- `ST_FILL_REPL` to `ST_RECORD`, and `ST_COPY` to `ST_RECORD`, on the last byte of the last row.
- `ST_RECORD` to `ST_IDLE` always.
- `ST_DRAIN` to `ST_IDLE` once the queue is empty.

Top module: `rfe_engine`

## Requirements
- R1: The byte address of byte k of pixel (x, y) is bypp·x + bypp·width·y + k. The row stride is bypp·width.
- R2: A fill writes byte k of every pixel with bits [8k+7:8k] of the colour (least significant byte first). It writes the top row first, and every row below it ends up equal to the top row.
- R3: A copy of a w×h rectangle leaves the destination equal to the source contents as they were before the copy, even when the two rectangles overlap. This holds whether the destination is below, above, left or right of the source.
- R4: `op_ready` is high only in the idle state. An `op_valid` seen while busy has no effect: it causes no memory write and no queued rectangle.
- R5: Every accepted operation pushes its destination rectangle (dx, dy, w, h) into the redraw queue once it completes.
- R6: On output, a rectangle with x+w beyond the width gets x = min(x, width) and w = width − x. The y and h fields are clipped the same way against the height. `upd_clipped` is 1 when either axis was clipped.
- R7: A flush accepted in idle with no invalidate pending emits the queued rectangles oldest first, one per cycle on `upd_valid`, until the queue is empty.
- R8: An `inval` pulse marks the queue as pending discard. The next accepted flush then empties it without emitting anything and clears the pending mark.
- R9: The queue holds up to QDEPTH−1 rectangles. Its indices wrap modulo QDEPTH, which must be a power of two. A push into a full queue drops the oldest entry.
- R10: An operation with w = 0 or h = 0 writes no memory but is still recorded.
- R11: After reset the engine is idle with `op_ready` = 1 and `upd_valid` = 0, and a flush emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bypp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_width | input | 12 | Screen width in pixels |
| cfg_height | input | 12 | Screen height in pixels |
| op_valid | input | 1 | Operation request, taken when op_ready is high |
| op_copy | input | 1 | 1 = copy, 0 = fill |
| op_color | input | 32 | Fill colour, low byte first |
| op_sx | input | 12 | Copy source x |
| op_sy | input | 12 | Copy source y |
| op_dx | input | 12 | Destination x |
| op_dy | input | 12 | Destination y |
| op_w | input | 12 | Rectangle width in pixels |
| op_h | input | 12 | Rectangle height in pixels |
| op_ready | output | 1 | Engine idle |
| flush_req | input | 1 | Drain or discard the redraw queue (idle only; an operation takes priority) |
| inval | input | 1 | Marks the queue for discard at the next flush |
| fb_raddr | output | AW | Framebuffer read byte address |
| fb_rdata | input | 8 | Framebuffer read data, same cycle |
| fb_we | output | 1 | Framebuffer write enable |
| fb_waddr | output | AW | Framebuffer write byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| upd_valid | output | 1 | A clipped update rectangle is presented |
| upd_x | output | 12 | Update x |
| upd_y | output | 12 | Update y |
| upd_w | output | 12 | Update width |
| upd_h | output | 12 | Update height |
| upd_clipped | output | 1 | The rectangle was clipped |

## Verification
The assertions check on every cycle that:
- memory writes and update outputs occur only while the engine is busy;
- an accepted operation leaves idle;
- every emitted rectangle lies within the screen;
- a push leaves the queue non-empty and a discard leaves it empty.

Only the bench scenarios can show the byte contents a fill or an overlapping copy leaves in memory, the order and clipping of drained rectangles, the drop-oldest behaviour of a full queue, and that a request during a busy operation leaves no trace.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
    parameter int unsigned RFE_CW = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_FIRST,
        ST_FILL_REPL,
        ST_COPY,
        ST_RECORD,
        ST_DRAIN
    } rfe_state_e;

    typedef struct packed {
        logic [RFE_CW-1:0] x;
        logic [RFE_CW-1:0] y;
        logic [RFE_CW-1:0] w;
        logic [RFE_CW-1:0] h;
    } rfe_rect_t;
endpackage

// File: rtl/rfe_redraw_q.sv
module rfe_redraw_q
    import rfe_pkg::*;
#(
    parameter int unsigned DEPTH = 512
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rfe_rect_t push_rect,
    input  logic      pop,
    input  logic      discard,
    output rfe_rect_t head,
    output logic      empty
);
    localparam int unsigned IW = $clog2(DEPTH);

    rfe_rect_t        store [DEPTH];
    logic [IW-1:0]    rd_idx, wr_idx;
    logic [IW-1:0]    wr_next;
    logic             full;

    assign wr_next = wr_idx + 1'b1;
    assign full    = (wr_next == rd_idx);
    assign empty   = (rd_idx == wr_idx);
    assign head    = store[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx <= '0;
            wr_idx <= '0;
        end else if (discard) begin
            rd_idx <= wr_idx;
        end else if (push) begin
            wr_idx <= wr_next;
            if (full) rd_idx <= rd_idx + 1'b1;
        end else if (pop && !empty) begin
            rd_idx <= rd_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !discard) store[wr_idx] <= push_rect;
    end

    // R8: a discard leaves nothing to drain
    p_discard_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> empty);
    // R5: a recorded rectangle is available afterwards
    p_push_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !discard) |=> !empty);
endmodule

// File: rtl/rfe_clip.sv
module rfe_clip
    import rfe_pkg::*;
(
    input  rfe_rect_t          rect_in,
    input  logic [RFE_CW-1:0]  scr_w,
    input  logic [RFE_CW-1:0]  scr_h,
    output rfe_rect_t          rect_out,
    output logic               clipped
);
    logic [RFE_CW-1:0] pos [2];
    logic [RFE_CW-1:0] len [2];
    logic [RFE_CW-1:0] lim [2];
    logic [RFE_CW-1:0] pos_o [2];
    logic [RFE_CW-1:0] len_o [2];
    logic [1:0]        over;

    assign pos[0] = rect_in.x;  assign len[0] = rect_in.w;  assign lim[0] = scr_w;
    assign pos[1] = rect_in.y;  assign len[1] = rect_in.h;  assign lim[1] = scr_h;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [RFE_CW:0] end_pt;
        assign end_pt   = {1'b0, pos[a]} + {1'b0, len[a]};
        assign over[a]  = end_pt > {1'b0, lim[a]};
        assign pos_o[a] = (pos[a] > lim[a]) ? lim[a] : pos[a];
        assign len_o[a] = over[a] ? (lim[a] - pos_o[a]) : len[a];
    end

    assign rect_out = '{x: pos_o[0], y: pos_o[1], w: len_o[0], h: len_o[1]};
    assign clipped  = |over;
endmodule

// File: rtl/rfe_engine.sv
module rfe_engine
    import rfe_pkg::*;
#(
    parameter int unsigned AW     = 20,
    parameter int unsigned QDEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_bypp,
    input  logic [RFE_CW-1:0] cfg_width,
    input  logic [RFE_CW-1:0] cfg_height,
    input  logic              op_valid,
    input  logic              op_copy,
    input  logic [31:0]       op_color,
    input  logic [RFE_CW-1:0] op_sx,
    input  logic [RFE_CW-1:0] op_sy,
    input  logic [RFE_CW-1:0] op_dx,
    input  logic [RFE_CW-1:0] op_dy,
    input  logic [RFE_CW-1:0] op_w,
    input  logic [RFE_CW-1:0] op_h,
    output logic              op_ready,
    input  logic              flush_req,
    input  logic              inval,
    output logic [AW-1:0]     fb_raddr,
    input  logic [7:0]        fb_rdata,
    output logic              fb_we,
    output logic [AW-1:0]     fb_waddr,
    output logic [7:0]        fb_wdata,
    output logic              upd_valid,
    output logic [RFE_CW-1:0] upd_x,
    output logic [RFE_CW-1:0] upd_y,
    output logic [RFE_CW-1:0] upd_w,
    output logic [RFE_CW-1:0] upd_h,
    output logic              upd_clipped
);
    localparam int unsigned CW = RFE_CW;

    rfe_state_e        state, state_nx;
    logic [31:0]       r_color;
    logic [CW-1:0]     r_sx, r_sy, r_dx, r_dy, r_w, r_h;
    logic              r_rev, inval_pend;
    logic [CW-1:0]     row_c;
    logic [AW-1:0]     col_c;
    logic [1:0]        phase;

    // address arithmetic (R1)
    logic [AW-1:0] bypp_a, stride, d_base, s_base, in_d_base, in_s_base;
    logic [AW-1:0] row_bytes, byte_i, row_off;
    logic [CW-1:0] row_i;
    logic          last_col, last_row, zero_op, pend_now, flush_go;
    logic [31:0]   color_sh;

    assign bypp_a    = AW'(cfg_bypp);
    assign stride    = bypp_a * AW'(cfg_width);
    assign d_base    = bypp_a * AW'(r_dx) + stride * AW'(r_dy);
    assign s_base    = bypp_a * AW'(r_sx) + stride * AW'(r_sy);
    assign in_d_base = bypp_a * AW'(op_dx) + stride * AW'(op_dy);
    assign in_s_base = bypp_a * AW'(op_sx) + stride * AW'(op_sy);
    assign row_bytes = bypp_a * AW'(r_w);
    assign row_i     = r_rev ? (r_h - 1'b1 - row_c) : row_c;
    assign byte_i    = r_rev ? (row_bytes - 1'b1 - col_c) : col_c;
    assign row_off   = stride * AW'(row_i);
    assign last_col  = (col_c == row_bytes - 1'b1);
    assign last_row  = (row_c == r_h - 1'b1);
    assign zero_op   = (op_w == '0) || (op_h == '0);
    assign pend_now  = inval_pend | inval;
    assign flush_go  = (state == ST_IDLE) && !op_valid && flush_req;
    assign color_sh  = r_color >> {phase, 3'b000};

    // redraw queue and output clipping
    rfe_rect_t q_head, q_in, clip_out;
    logic      q_empty, q_push, q_pop, q_discard;

    assign q_in      = '{x: r_dx, y: r_dy, w: r_w, h: r_h};
    assign q_push    = (state == ST_RECORD);
    assign q_pop     = (state == ST_DRAIN) && !q_empty;
    assign q_discard = flush_go && pend_now;

    rfe_redraw_q #(.DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_rect(q_in),
        .pop(q_pop), .discard(q_discard), .head(q_head), .empty(q_empty)
    );

    rfe_clip u_clip (
        .rect_in(q_head), .scr_w(cfg_width), .scr_h(cfg_height),
        .rect_out(clip_out), .clipped(upd_clipped)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (op_valid)
                    state_nx = zero_op ? ST_RECORD : (op_copy ? ST_COPY : ST_FILL_FIRST);
                else if (flush_go && !pend_now && !q_empty)
                    state_nx = ST_DRAIN;
            end
            ST_FILL_FIRST: if (last_col) state_nx = last_row ? ST_RECORD : ST_FILL_REPL;
            ST_FILL_REPL:  if (last_col && last_row) state_nx = ST_RECORD;
            ST_COPY:       if (last_col && last_row) state_nx = ST_RECORD;
            ST_RECORD:     state_nx = ST_IDLE;
            ST_DRAIN:      if (q_empty) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // state register and walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            r_color    <= '0;
            r_sx       <= '0; r_sy <= '0; r_dx <= '0; r_dy <= '0;
            r_w        <= '0; r_h  <= '0;
            r_rev      <= 1'b0;
            row_c      <= '0;
            col_c      <= '0;
            phase      <= '0;
            inval_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (q_discard)  inval_pend <= 1'b0;
            else if (inval) inval_pend <= 1'b1;
            unique case (state)
                ST_IDLE: if (op_valid) begin
                    r_color <= op_color;
                    r_sx <= op_sx; r_sy <= op_sy; r_dx <= op_dx; r_dy <= op_dy;
                    r_w  <= op_w;  r_h  <= op_h;
                    r_rev <= op_copy && (in_d_base > in_s_base);
                    row_c <= '0;
                    col_c <= '0;
                    phase <= '0;
                end
                ST_FILL_FIRST: begin
                    phase <= (phase == 2'(cfg_bypp - 3'd1)) ? 2'd0 : phase + 2'd1;
                    if (last_col) begin
                        col_c <= '0;
                        row_c <= CW'(1);
                    end else begin
                        col_c <= col_c + 1'b1;
                    end
                end
                ST_FILL_REPL, ST_COPY: begin
                    if (last_col) begin
                        col_c <= '0;
                        row_c <= row_c + 1'b1;
                    end else begin
                        col_c <= col_c + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fb_we    = 1'b0;
        fb_raddr = '0;
        fb_waddr = '0;
        fb_wdata = '0;
        unique case (state)
            ST_FILL_FIRST: begin
                fb_we    = 1'b1;
                fb_waddr = d_base + byte_i;
                fb_wdata = color_sh[7:0];
            end
            ST_FILL_REPL: begin
                fb_we    = 1'b1;
                fb_raddr = d_base + byte_i;
                fb_waddr = d_base + row_off + byte_i;
                fb_wdata = fb_rdata;
            end
            ST_COPY: begin
                fb_we    = 1'b1;
                fb_raddr = s_base + row_off + byte_i;
                fb_waddr = d_base + row_off + byte_i;
                fb_wdata = fb_rdata;
            end
            default: ;
        endcase
    end

    assign op_ready  = (state == ST_IDLE);
    assign upd_valid = (state == ST_DRAIN) && !q_empty;
    assign upd_x     = clip_out.x;
    assign upd_y     = clip_out.y;
    assign upd_w     = clip_out.w;
    assign upd_h     = clip_out.h;

    // R4: memory is written only while an operation runs
    p_we_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> !op_ready);
    // R4: an accepted request leaves idle
    p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid) |=> !op_ready);
    // R7: updates are emitted only while draining
    p_upd_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !op_ready);
    // R6: emitted rectangles stay on screen
    p_clip_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (({1'b0, upd_x} + {1'b0, upd_w} <= {1'b0, cfg_width}) &&
                       ({1'b0, upd_y} + {1'b0, upd_h} <= {1'b0, cfg_height})));
endmodule

// File: tb/rfe_engine_tb.sv
`timescale 1ns/1ps
module rfe_engine_tb_top;
    localparam int AW = 20;
    localparam int QD = 512;
    localparam int MB = 4096;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0]  cfg_bypp = 3'd1;
    logic [11:0] cfg_width = 12'd16, cfg_height = 12'd8;
    logic op_valid = 0, op_copy = 0, flush_req = 0, inval = 0;
    logic [31:0] op_color = 0;
    logic [11:0] op_sx = 0, op_sy = 0, op_dx = 0, op_dy = 0, op_w = 0, op_h = 0;
    logic op_ready, fb_we, upd_valid, upd_clipped;
    logic [AW-1:0] fb_raddr, fb_waddr;
    logic [7:0] fb_rdata, fb_wdata;
    logic [11:0] upd_x, upd_y, upd_w, upd_h;

    int nchk = 0, nerr = 0;
    logic [7:0] fbm  [MB];
    logic [7:0] refm [MB];
    logic [7:0] tmp  [MB];
    int exq_x [QD], exq_y [QD], exq_w [QD], exq_h [QD];
    int exq_n = 0;

    always #2 clk = ~clk;

    assign fb_rdata = fbm[fb_raddr[11:0]];
    always @(posedge clk) if (fb_we) fbm[fb_waddr[11:0]] <= fb_wdata;

    rfe_engine #(.AW(AW), .QDEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bypp(cfg_bypp), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .op_valid(op_valid), .op_copy(op_copy),
        .op_color(op_color), .op_sx(op_sx), .op_sy(op_sy), .op_dx(op_dx),
        .op_dy(op_dy), .op_w(op_w), .op_h(op_h), .op_ready(op_ready),
        .flush_req(flush_req), .inval(inval), .fb_raddr(fb_raddr),
        .fb_rdata(fb_rdata), .fb_we(fb_we), .fb_waddr(fb_waddr),
        .fb_wdata(fb_wdata), .upd_valid(upd_valid), .upd_x(upd_x),
        .upd_y(upd_y), .upd_w(upd_w), .upd_h(upd_h), .upd_clipped(upd_clipped)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int paddr(input int x, input int y);
        return cfg_bypp * x + cfg_bypp * cfg_width * y;
    endfunction

    function automatic longint clip_pack(input int x, input int y, input int w, input int h);
        int cx, cy, cw, ch, f;
        f = 0;
        cx = (x > cfg_width) ? int'(cfg_width) : x;
        cy = (y > cfg_height) ? int'(cfg_height) : y;
        cw = w; ch = h;
        if (x + w > cfg_width)  begin cw = cfg_width - cx;  f = 1; end
        if (y + h > cfg_height) begin ch = cfg_height - cy; f = 1; end
        return (longint'(f) << 48) | (longint'(cx) << 36) | (longint'(cy) << 24) |
               (longint'(cw) << 12) | longint'(ch);
    endfunction

    task automatic expect_push(input int x, input int y, input int w, input int h);
        if (exq_n == QD - 1) begin
            for (int i = 1; i < exq_n; i++) begin
                exq_x[i-1] = exq_x[i]; exq_y[i-1] = exq_y[i];
                exq_w[i-1] = exq_w[i]; exq_h[i-1] = exq_h[i];
            end
            exq_n--;
        end
        exq_x[exq_n] = x; exq_y[exq_n] = y; exq_w[exq_n] = w; exq_h[exq_n] = h;
        exq_n++;
    endtask

    task automatic model_op(input bit cp, input logic [31:0] col,
                            input int sx, input int sy, input int dx, input int dy,
                            input int w, input int h);
        int rb, st;
        rb = cfg_bypp * w;
        st = cfg_bypp * cfg_width;
        if (cp) begin
            for (int r = 0; r < h; r++)
                for (int c = 0; c < rb; c++)
                    tmp[r*rb + c] = refm[(paddr(sx, sy) + r*st + c) % MB];
            for (int r = 0; r < h; r++)
                for (int c = 0; c < rb; c++)
                    refm[(paddr(dx, dy) + r*st + c) % MB] = tmp[r*rb + c];
        end else begin
            for (int r = 0; r < h; r++)
                for (int c = 0; c < rb; c++)
                    refm[(paddr(dx, dy) + r*st + c) % MB] = 8'(col >> (8 * (c % cfg_bypp)));
        end
        expect_push(dx, dy, w, h);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20000 && !op_ready; i++) @(negedge clk);
    endtask

    task automatic drive(input bit cp, input logic [31:0] col,
                         input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h);
        op_copy = cp; op_color = col;
        op_sx = 12'(sx); op_sy = 12'(sy); op_dx = 12'(dx); op_dy = 12'(dy);
        op_w = 12'(w); op_h = 12'(h); op_valid = 1'b1;
    endtask

    task automatic run_op(input bit cp, input logic [31:0] col,
                          input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h);
        @(negedge clk);
        drive(cp, col, sx, sy, dx, dy, w, h);
        @(negedge clk);
        op_valid = 1'b0;
        wait_ready();
        model_op(cp, col, sx, sy, dx, dy, w, h);
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < MB; i++) if (bad < 0 && fbm[i] !== refm[i]) bad = i;
        if (bad >= 0) chk(tag, fbm[bad], refm[bad]);
        else chk(tag, 0, 0);
    endtask

    task automatic do_flush(input string tag);
        int got;
        got = 0;
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        for (int i = 0; i < QD + 4 && upd_valid; i++) begin
            if (got < exq_n)
                chk(tag, {upd_clipped, upd_x, upd_y, upd_w, upd_h},
                    clip_pack(exq_x[got], exq_y[got], exq_w[got], exq_h[got]));
            got++;
            @(negedge clk);
        end
        chk({tag, " count"}, got, exq_n);
        exq_n = 0;
        wait_ready();
    endtask

    task automatic t_reset();
        chk("R11 ready after reset", op_ready, 1);
        chk("R11 no update after reset", upd_valid, 0);
        do_flush("R11 empty queue");
    endtask

    task automatic t_fill();
        cfg_bypp = 3'd3; cfg_width = 12'd16; cfg_height = 12'd8;
        run_op(0, 32'h00A1B2C3, 0, 0, 2, 1, 5, 3);
        cmp_mem("R2 R1 fill bypp3");
        cfg_bypp = 3'd1;
        run_op(0, 32'h0000005A, 0, 0, 3, 2, 7, 1);
        cmp_mem("R2 fill bypp1 single row");
        cfg_bypp = 3'd4;
        run_op(0, 32'hDEADBEEF, 0, 0, 1, 2, 3, 4);
        cmp_mem("R2 R1 fill bypp4");
        do_flush("R5 R7 fill records");
    endtask

    task automatic t_copy();
        cfg_bypp = 3'd2; cfg_width = 12'd16; cfg_height = 12'd8;
        run_op(1, 0, 0, 0, 9, 5, 4, 2);
        cmp_mem("R3 copy disjoint");
        run_op(1, 0, 4, 1, 2, 2, 6, 3);
        cmp_mem("R3 copy overlap dest below");
        run_op(1, 0, 2, 3, 5, 1, 6, 4);
        cmp_mem("R3 copy overlap dest above");
        run_op(1, 0, 1, 4, 3, 4, 8, 2);
        cmp_mem("R3 copy same rows shift right");
        run_op(1, 0, 5, 6, 2, 6, 8, 2);
        cmp_mem("R3 copy same rows shift left");
        do_flush("R5 R7 copy records in order");
    endtask

    task automatic t_clip();
        cfg_bypp = 3'd1; cfg_width = 12'd16; cfg_height = 12'd8;
        run_op(0, 32'h77, 0, 0, 14, 6, 4, 3);
        run_op(0, 32'h66, 0, 0, 1, 1, 2, 2);
        cmp_mem("R1 clip fill memory");
        do_flush("R6 clipped rect");
    endtask

    task automatic t_busy_ignore();
        cfg_bypp = 3'd2;
        @(negedge clk);
        drive(0, 32'h1234, 0, 0, 0, 0, 6, 3);
        @(negedge clk);
        drive(0, 32'h9999, 0, 0, 8, 4, 3, 2);
        @(negedge clk);
        op_valid = 1'b0;
        wait_ready();
        model_op(0, 32'h1234, 0, 0, 0, 0, 6, 3);
        cmp_mem("R4 busy request wrote nothing");
        do_flush("R4 busy request not recorded");
    endtask

    task automatic t_zero();
        cfg_bypp = 3'd2;
        run_op(0, 32'hFFFF, 0, 0, 3, 3, 0, 4);
        run_op(1, 0, 1, 1, 6, 2, 5, 0);
        cmp_mem("R10 zero size writes nothing");
        do_flush("R10 zero size recorded");
    endtask

    task automatic t_inval();
        cfg_bypp = 3'd1;
        run_op(0, 32'h11, 0, 0, 0, 0, 2, 2);
        run_op(0, 32'h22, 0, 0, 4, 4, 2, 2);
        @(negedge clk); inval = 1'b1;
        @(negedge clk); inval = 1'b0;
        exq_n = 0;
        do_flush("R8 invalidate discards");
        run_op(0, 32'h33, 0, 0, 5, 1, 1, 1);
        do_flush("R8 pending cleared");
    endtask

    task automatic t_overflow();
        cfg_bypp = 3'd1; cfg_width = 12'd16; cfg_height = 12'd64;
        for (int k = 0; k < QD; k++) run_op(0, 0, 0, 0, k % 16, k / 16, 0, 0);
        chk("R9 model keeps depth-1", exq_n, QD - 1);
        chk("R9 oldest survivor", exq_x[0] + 16 * exq_y[0], 1);
        do_flush("R9 full queue drops oldest");
    endtask

    initial begin
        #600000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < MB; i++) begin
            fbm[i]  = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_copy();
        t_clip();
        t_busy_ignore();
        t_zero();
        t_inval();
        t_overflow();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule